// File: doc/BRIEF.md
# Serial Video Word Aligner

This block takes a serial digital video stream one bit per clock, with a qualifier that marks the cycles that carry a bit. It undoes the line coding, which is a transition (NRZI) code followed by a self-synchronizing scrambler with polynomial x^9 + x^4 + 1. It then searches the recovered bits for the three-word line preamble and presents aligned 10-bit parallel words, each marked by a one-cycle valid strobe.

On every accepted preamble an hsync line changes level. Only the moment of the change matters. The change comes one word period ahead of the first preamble word on the parallel output, so a downstream framer can get ready for it. A correction policy decides when the internal word timing may shift to a preamble found at an unexpected bit offset. With the policy on, one stray preamble is tolerated. With it off, the block re-phases at once. Each misaligned preamble is reported on a one-cycle error pulse.

Neither stream edge has back-pressure. The serial side cannot be stalled: `ser_valid` low only pauses the block. The parallel side has no ready, so a consumer must take each word on its strobe. The word then stays on `par_data` until the next strobe.

Top module: `video_word_aligner`

## Requirements
- R1: While reset is held, `par_data` is 0 and `par_valid`, `hsync` and `sync_err` are all low.
- R2: Each parallel word equals the source word as it was before line coding. Decoding inverts NRZI (x+1) and the x^9+x^4+1 self-synchronizing scrambler, and both start from an all-zero history at reset.
- R3: The first serial bit of a word becomes `par_data[0]` and the tenth becomes `par_data[9]`.
- R4: `par_valid` is high for one cycle after every 10 accepted bits of the current word timing. `par_data` changes only in a strobe cycle.
- R5: A preamble is three consecutive words: a first word whose bits 9..2 are all ones (bits 1..0 are ignored, so 8-bit sources are covered), followed by two words of all zeros.
- R6: `hsync` toggles exactly once per accepted preamble. The toggle occurs on the strobe just before the strobe that carries the first preamble word.
- R7: With `corr_en` high, a first misaligned preamble leaves the word timing and `hsync` unchanged. The next misaligned preamble re-phases the word timing to itself.
- R8: An aligned preamble clears any pending misalignment, so the next misaligned preamble is again ignored.
- R9: With `corr_en` low, every misaligned preamble re-phases the word timing and toggles `hsync` at once.
- R10: `sync_err` is a one-cycle pulse for every misaligned preamble, whether ignored or acted on. It never fires for an aligned one.
- R11: Cycles with `ser_valid` low change no state: no strobe, no data change, no `hsync` toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_bit | input | 1 | Line-coded serial bit |
| ser_valid | input | 1 | `ser_bit` carries a bit this cycle |
| corr_en | input | 1 | Tolerate one misaligned preamble before re-phasing |
| par_data | output | 10 | Aligned decoded word, bit 0 first received |
| par_valid | output | 1 | One-cycle strobe for a new word |
| hsync | output | 1 | Toggles once per accepted preamble |
| sync_err | output | 1 | One-cycle pulse on a misaligned preamble |

## Verification
The bench builds the block with its defaults: 10-bit words, a three-word preamble with two ignored low bits in the first word, and scrambler taps 4 and 9. These values let a bench model of the line coder check every decoded word exactly, starting from reset. Inserting 3, 4 or 7 filler bits moves preambles to known offsets from the current word timing, which exercises the hold, re-phase and clear paths of the correction policy. The 8-bit preamble form and idle gaps inside words are also exercised.

// File: rtl/vwa_pkg.sv
package vwa_pkg;
  typedef enum logic [1:0] {
    DET_NONE,
    DET_ALIGNED,
    DET_HOLD,
    DET_REPHASE
  } det_e;
endpackage

// File: rtl/vwa_descrambler.sv
module vwa_descrambler #(
  parameter int TAP_A = 4,
  parameter int TAP_B = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_in,
  input  logic bit_vld,
  output logic bit_out
);
  logic             line_q;
  logic [TAP_B-1:0] hist_q;
  logic             unnrzi;

  // undo transition coding, then the feed-back scrambler
  assign unnrzi  = bit_in ^ line_q;
  assign bit_out = unnrzi ^ hist_q[TAP_A-1] ^ hist_q[TAP_B-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= 1'b0;
      hist_q <= '0;
    end else if (bit_vld) begin
      line_q <= bit_in;
      hist_q <= {hist_q[TAP_B-2:0], unnrzi};
    end
  end
endmodule

// File: rtl/vwa_framer.sv
module vwa_framer #(
  parameter int WORD_W    = 10,
  parameter int PRE_WORDS = 3,
  parameter int LSB_IGN   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_in,
  input  logic              bit_vld,
  output logic [WORD_W-1:0] oldest_word,
  output logic              pre_hit
);
  localparam int SR_W = WORD_W * PRE_WORDS;

  logic [SR_W-2:0]      sr_q;
  logic [SR_W-1:0]      sr_nx;
  logic [PRE_WORDS-2:0] zero_w;

  // newest bit enters at the top; the oldest word sits at the bottom
  assign sr_nx       = {bit_in, sr_q};
  assign oldest_word = sr_nx[WORD_W-1:0];

  for (genvar g = 1; g < PRE_WORDS; g++) begin : g_zero
    assign zero_w[g-1] = ~|sr_nx[g*WORD_W +: WORD_W];
  end

  assign pre_hit = (&sr_nx[WORD_W-1:LSB_IGN]) && (&zero_w);

  always_ff @(posedge clk) begin
    if (!rst_n)       sr_q <= '0;
    else if (bit_vld) sr_q <= sr_nx[SR_W-1:1];
  end
endmodule

// File: rtl/vwa_align_ctl.sv
module vwa_align_ctl
  import vwa_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_vld,
  input  logic              pre_hit,
  input  logic              corr_en,
  input  logic [WORD_W-1:0] oldest_word,
  output logic [WORD_W-1:0] par_data,
  output logic              par_valid,
  output logic              hsync,
  output logic              sync_err
);
  localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0]  phase_q;
  logic              pend_q;
  logic [WORD_W-1:0] stage_q;
  det_e              det;
  logic              boundary;

  always_comb begin
    det = DET_NONE;
    if (bit_vld && pre_hit) begin
      if (phase_q == LAST)        det = DET_ALIGNED;
      else if (!corr_en || pend_q) det = DET_REPHASE;
      else                         det = DET_HOLD;
    end
  end

  assign boundary = bit_vld && ((phase_q == LAST) || (det == DET_REPHASE));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= '0;
      pend_q    <= 1'b0;
      stage_q   <= '0;
      par_data  <= '0;
      par_valid <= 1'b0;
      hsync     <= 1'b0;
      sync_err  <= 1'b0;
    end else begin
      par_valid <= boundary;
      sync_err  <= (det == DET_HOLD) || (det == DET_REPHASE);
      if (bit_vld) phase_q <= boundary ? '0 : phase_q + 1'b1;
      if (boundary) begin
        stage_q  <= oldest_word;
        par_data <= stage_q;
      end
      if ((det == DET_ALIGNED) || (det == DET_REPHASE)) hsync <= ~hsync;
      case (det)
        DET_ALIGNED, DET_REPHASE: pend_q <= 1'b0;
        DET_HOLD:                 pend_q <= 1'b1;
        default:                  pend_q <= pend_q;
      endcase
    end
  end
endmodule

// File: rtl/video_word_aligner.sv
module video_word_aligner #(
  parameter int WORD_W    = 10,
  parameter int PRE_WORDS = 3,
  parameter int LSB_IGN   = 2,
  parameter int TAP_A     = 4,
  parameter int TAP_B     = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_bit,
  input  logic              ser_valid,
  input  logic              corr_en,
  output logic [WORD_W-1:0] par_data,
  output logic              par_valid,
  output logic              hsync,
  output logic              sync_err
);
  logic              plain_bit;
  logic [WORD_W-1:0] oldest_word;
  logic              pre_hit;

  vwa_descrambler #(.TAP_A(TAP_A), .TAP_B(TAP_B)) u_dscr (
    .clk(clk), .rst_n(rst_n), .bit_in(ser_bit), .bit_vld(ser_valid),
    .bit_out(plain_bit)
  );

  vwa_framer #(.WORD_W(WORD_W), .PRE_WORDS(PRE_WORDS), .LSB_IGN(LSB_IGN)) u_frm (
    .clk(clk), .rst_n(rst_n), .bit_in(plain_bit), .bit_vld(ser_valid),
    .oldest_word(oldest_word), .pre_hit(pre_hit)
  );

  vwa_align_ctl #(.WORD_W(WORD_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .bit_vld(ser_valid), .pre_hit(pre_hit),
    .corr_en(corr_en), .oldest_word(oldest_word),
    .par_data(par_data), .par_valid(par_valid), .hsync(hsync), .sync_err(sync_err)
  );
endmodule

// File: rtl/vwa_checker.sv
module vwa_checker #(
  parameter int WORD_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ser_valid,
  input logic              corr_en,
  input logic [WORD_W-1:0] par_data,
  input logic              par_valid,
  input logic              hsync,
  input logic              sync_err
);
  // R4
  stb_after_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_valid |-> $past(ser_valid));
  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !par_valid |-> $stable(par_data));
  // R6
  hsync_on_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hsync) |-> par_valid);
  // R10
  err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |=> !sync_err);
  // R9
  nocorr_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_err && !$past(corr_en)) |-> !$stable(hsync));
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ser_valid) |-> (!par_valid && !sync_err && $stable(hsync)));
endmodule

bind video_word_aligner vwa_checker #(.WORD_W(WORD_W)) u_vwa_chk (
  .clk(clk), .rst_n(rst_n), .ser_valid(ser_valid), .corr_en(corr_en),
  .par_data(par_data), .par_valid(par_valid), .hsync(hsync), .sync_err(sync_err)
);

// File: tb/test_video_word_aligner.sv
module test_video_word_aligner;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [9:0] word;
    logic       pre;
  } vec_t;

  localparam vec_t VEC [16] = '{
    '{10'h155, 1'b0}, '{10'h2AA, 1'b0}, '{10'h3FF, 1'b1}, '{10'h000, 1'b0},
    '{10'h000, 1'b0}, '{10'h123, 1'b0}, '{10'h0F0, 1'b0}, '{10'h30C, 1'b0},
    '{10'h3FC, 1'b1}, '{10'h000, 1'b0}, '{10'h000, 1'b0}, '{10'h2D4, 1'b0},
    '{10'h1A6, 1'b0}, '{10'h3C3, 1'b0}, '{10'h155, 1'b0}, '{10'h2AA, 1'b0}
  };

  logic       clk = 0, rst_n = 0, ser_bit = 0, ser_valid = 0, corr_en = 1;
  logic [9:0] par_data;
  logic       par_valid, hsync, sync_err;

  video_word_aligner i_video_word_aligner (
    .clk(clk), .rst_n(rst_n), .ser_bit(ser_bit), .ser_valid(ser_valid),
    .corr_en(corr_en), .par_data(par_data), .par_valid(par_valid),
    .hsync(hsync), .sync_err(sync_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  logic [8:0] scr_q = '0;
  logic       line_q = 1'b0;

  logic [9:0] outw [0:1023];
  bit         tog  [0:1023];
  int         bpos [0:1023];
  int nrec = 0, ntog = 0, nerr = 0, bits_tot = 0;
  logic hs_prev = 1'b0;

  always @(posedge clk) if (rst_n && ser_valid) bits_tot++;

  always @(negedge clk) if (rst_n) begin
    if (par_valid && nrec < 1024) begin
      outw[nrec] = par_data;
      tog[nrec]  = (hsync != hs_prev);
      bpos[nrec] = bits_tot;
      nrec++;
    end
    if (hsync != hs_prev) ntog++;
    if (sync_err) nerr++;
    hs_prev = hsync;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // bench line coder: scrambler x^9+x^4+1 then NRZI
  task automatic send_bit(input logic x);
    logic y;
    @(negedge clk);
    y      = x ^ scr_q[3] ^ scr_q[8];
    scr_q  = {scr_q[7:0], y};
    line_q = line_q ^ y;
    ser_bit   = line_q;
    ser_valid = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ser_valid = 1'b0;
    end
  endtask

  task automatic send_word(input logic [9:0] w);
    for (int i = 0; i < 10; i++) send_bit(w[i]);
  endtask

  task automatic send_fill(input int n);
    for (int i = 0; i < n; i++) send_bit(i[0]);
  endtask

  task automatic send_pre();
    send_word(10'h3FF); send_word(10'h000); send_word(10'h000);
  endtask

  task automatic flush();
    for (int i = 0; i < 4; i++) send_word(10'h155);
    idle(3);
  endtask

  function automatic int find_tog(input int from);
    for (int k = from; k < nrec; k++) if (tog[k]) return k;
    return -1;
  endfunction

  // after a toggle at strobe i: the preamble, then the listed data words
  task automatic check_after(input int i, input string req,
                             input logic [9:0] d0, input logic [9:0] d1);
    chk(i >= 0, {req, " toggle found"}, i, 0);
    if (i >= 0) begin
      chk(outw[i+1] == 10'h3FF, req, outw[i+1], 10'h3FF);
      chk(outw[i+2] == 10'h000, req, outw[i+2], 10'h000);
      chk(outw[i+3] == 10'h000, req, outw[i+3], 10'h000);
      chk(outw[i+4] == d0, req, outw[i+4], d0);
      chk(outw[i+5] == d1, req, outw[i+5], d1);
      chk(bpos[i+1] - bpos[i] == 10, {req, " R4 spacing"}, bpos[i+1] - bpos[i], 10);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base, t0, e0, i;
    // R1: reset state
    repeat (4) @(negedge clk);
    chk(par_data == 10'h000, "R1 par_data", par_data, 0);
    chk(par_valid == 1'b0, "R1 par_valid", par_valid, 0);
    chk(hsync == 1'b0, "R1 hsync", hsync, 0);
    chk(sync_err == 1'b0, "R1 sync_err", sync_err, 0);
    rst_n = 1'b1;

    // table walk: R2 R3 R5 R6 R4 R10
    foreach (VEC[j]) send_word(VEC[j].word);
    flush();
    for (int j = 0; j < 16; j++) begin
      chk(outw[j+3] == VEC[j].word, "R2 R3 word", outw[j+3], VEC[j].word);
      chk(tog[j+2] == VEC[j].pre, "R5 R6 hsync lead", tog[j+2], VEC[j].pre);
      chk(bpos[j+3] - bpos[j+2] == 10, "R4 spacing", bpos[j+3] - bpos[j+2], 10);
    end
    chk(nerr == 0, "R10 no error when aligned", nerr, 0);
    chk(ntog == 2, "R6 toggle count", ntog, 2);

    // R7: one stray preamble held, second re-phases
    base = nrec; t0 = ntog; e0 = nerr;
    send_fill(3);
    send_pre();
    send_word(10'h2AA); send_word(10'h133); send_word(10'h0F0); send_word(10'h3C3);
    send_pre();
    send_word(10'h2D4); send_word(10'h1A6);
    flush();
    i = find_tog(base);
    chk(ntog - t0 == 1, "R7 single toggle", ntog - t0, 1);
    chk(nerr - e0 == 2, "R7 R10 two errors", nerr - e0, 2);
    for (int k = base + 1; k < i; k++)
      chk(bpos[k] - bpos[k-1] == 10, "R7 timing held", bpos[k] - bpos[k-1], 10);
    check_after(i, "R7 re-phase", 10'h2D4, 10'h1A6);

    // R8: aligned preamble clears pending misalignment
    base = nrec; t0 = ntog; e0 = nerr;
    send_fill(3);
    send_pre();
    send_word(10'h155); send_word(10'h2AA);
    send_fill(7);
    send_pre();
    send_word(10'h30C); send_word(10'h123);
    send_fill(3);
    send_pre();
    send_word(10'h155); send_word(10'h2AA); send_word(10'h0F0);
    flush();
    i = find_tog(base);
    chk(ntog - t0 == 1, "R8 only aligned toggles", ntog - t0, 1);
    chk(nerr - e0 == 2, "R8 R10 errors", nerr - e0, 2);
    check_after(i, "R8 aligned", 10'h30C, 10'h123);

    // R9: correction off re-phases at once
    corr_en = 1'b0;
    base = nrec; t0 = ntog; e0 = nerr;
    send_fill(4);
    send_pre();
    send_word(10'h1A6); send_word(10'h3C3);
    flush();
    i = find_tog(base);
    chk(ntog - t0 == 1, "R9 toggle", ntog - t0, 1);
    chk(nerr - e0 == 1, "R9 R10 error", nerr - e0, 1);
    check_after(i, "R9 re-phase", 10'h1A6, 10'h3C3);
    corr_en = 1'b1;

    // R11: idle gaps inside words change nothing
    base = nrec; t0 = ntog; e0 = nerr;
    for (int w = 0; w < 6; w++) begin
      logic [9:0] gw;
      gw = (w == 0) ? 10'h3FF : (w < 3) ? 10'h000 : (w == 3) ? 10'h2D4 : 10'h0F0;
      for (int b = 0; b < 10; b++) begin
        send_bit(gw[b]);
        if (b % 4 == 3) begin
          logic [9:0] snap;
          @(negedge clk);
          ser_valid = 1'b0;
          snap = par_data;
          @(negedge clk);
          chk(par_data == snap && !par_valid, "R11 idle hold", par_data, snap);
        end
      end
    end
    flush();
    i = find_tog(base);
    chk(ntog - t0 == 1, "R11 toggle", ntog - t0, 1);
    chk(nerr - e0 == 0, "R11 R10 no error", nerr - e0, 0);
    check_after(i, "R11 gaps", 10'h2D4, 10'h0F0);
    for (int k = base + 1; k < nrec; k++)
      chk(bpos[k] - bpos[k-1] == 10, "R11 R4 valid-bit spacing", bpos[k] - bpos[k-1], 10);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule